// File: doc/BRIEF.md
# Battery Backup Switchover Controller

This block chooses the supply that feeds a backed-up rail, such as the rail of a static RAM that must keep its contents when the main supply fails. Each clock it reads three millivolt codes: the main supply, the backup battery, and the low-voltage trip level of the main supply. It then decides whether the rail should come from the main supply or from the battery.

The decision has two tiers. While the main supply is above the trip level, the main supply is always chosen. At or below the trip level, the main supply is compared with the battery inside a hysteresis band of ±`HYST_MV` (30 mV by default). Inside that band the last choice is held.

The decision goes to the external power switches as two one-hot enables. A sequencer opens both switches for one cycle before it closes the other one. A battery-on indicator follows the battery switch. A backup-mode flag reports the decision itself, so that the watchdog logic can pause as soon as the battery is chosen.

Top module: `batt_switchover`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `main_en`=1, `batt_en`=0, `batt_on`=0 and `backup_mode`=0.
- R2: When `main_mv` > `trip_mv` (strictly), the decision is the main supply whatever `batt_mv` is, and `backup_mode` is 0 one cycle later.
- R3: When `main_mv` <= `trip_mv` and `main_mv` < `batt_mv` − `HYST_MV`, the decision is the battery.
- R4: When `main_mv` <= `trip_mv` and `main_mv` > `batt_mv` + `HYST_MV`, the decision is the main supply.
- R5: When `main_mv` <= `trip_mv` and `main_mv` lies within `batt_mv` ± `HYST_MV` (both ends included), the previous decision is kept.
- R6: All comparisons are signed. A `batt_mv` below `HYST_MV` never wraps around: for example, `batt_mv`=10 and `main_mv`=0 is inside the band, so the decision is held.
- R7: `main_en` and `batt_en` are never both 1.
- R8: Every change of source passes through exactly one cycle with both enables at 0. Inputs present before clock edge k set the decision at edge k. Both enables drop at edge k+1, and the new enable rises at edge k+2.
- R9: `batt_on` is 1 exactly when `batt_en` is 1.
- R10: `backup_mode` is 1 exactly when the registered decision is the battery. It changes at the same edge as the decision, two edges before the battery switch closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_mv | input | MV_W | Main supply level in mV |
| batt_mv | input | MV_W | Battery level in mV |
| trip_mv | input | MV_W | Main supply low-voltage trip level in mV |
| main_en | output | 1 | Closes the main-supply switch |
| batt_en | output | 1 | Closes the battery switch |
| batt_on | output | 1 | High while the battery feeds the rail |
| backup_mode | output | 1 | Battery decision in force; pauses the watchdog |

## Verification
The assertions check on every cycle that the two enables are never on together, that each enable rises only after a cycle in which the other was off, and that a main level above the trip forces a main decision. They also check that `batt_on` rises only after backup mode has been entered. Only the bench's ramps can show the hysteresis memory and the thresholds at the band edges. The same holds for the held decision at tiny battery codes and the exact two-edge delay from decision to switch closure. The bench shows these by ramping the main supply down and up across several battery and trip levels, against an arithmetic model.

// File: rtl/swo_pkg.sv
package swo_pkg;
  typedef enum logic [1:0] {
    PATH_MAIN = 2'd0,
    PATH_GAP  = 2'd1,
    PATH_BATT = 2'd2
  } path_t;
endpackage

// File: rtl/swo_decide.sv
module swo_decide #(
  parameter int MV_W    = 13,
  parameter int HYST_MV = 30
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [MV_W-1:0] main_mv,
  input  logic [MV_W-1:0] batt_mv,
  input  logic [MV_W-1:0] trip_mv,
  output logic            want_batt
);
  localparam int EXT_W = MV_W + 2;
  localparam logic signed [EXT_W-1:0] HYS = HYST_MV[EXT_W-1:0];

  logic signed [EXT_W-1:0] m_s, b_s, t_s;
  logic above_trip, under_band, over_band, nxt;

  assign m_s = $signed({2'b00, main_mv});
  assign b_s = $signed({2'b00, batt_mv});
  assign t_s = $signed({2'b00, trip_mv});

  assign above_trip = m_s > t_s;
  assign under_band = m_s < (b_s - HYS);
  assign over_band  = m_s > (b_s + HYS);

  always_comb begin
    nxt = want_batt;
    if (above_trip)      nxt = 1'b0;
    else if (under_band) nxt = 1'b1;
    else if (over_band)  nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) want_batt <= 1'b0;
    else     want_batt <= nxt;
  end
endmodule

// File: rtl/swo_bbm.sv
module swo_bbm
  import swo_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic want_batt,
  output logic main_en,
  output logic batt_en,
  output logic batt_on
);
  path_t path_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      path_q  <= PATH_MAIN;
      main_en <= 1'b1;
      batt_en <= 1'b0;
      batt_on <= 1'b0;
    end else begin
      case (path_q)
        PATH_MAIN: if (want_batt) begin
          path_q  <= PATH_GAP;
          main_en <= 1'b0;
        end
        PATH_BATT: if (!want_batt) begin
          path_q  <= PATH_GAP;
          batt_en <= 1'b0;
          batt_on <= 1'b0;
        end
        default: begin
          path_q  <= want_batt ? PATH_BATT : PATH_MAIN;
          main_en <= !want_batt;
          batt_en <= want_batt;
          batt_on <= want_batt;
        end
      endcase
    end
  end
endmodule

// File: rtl/batt_switchover.sv
module batt_switchover #(
  parameter int MV_W    = 13,
  parameter int HYST_MV = 30
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [MV_W-1:0] main_mv,
  input  logic [MV_W-1:0] batt_mv,
  input  logic [MV_W-1:0] trip_mv,
  output logic            main_en,
  output logic            batt_en,
  output logic            batt_on,
  output logic            backup_mode
);
  logic want_batt;

  swo_decide #(.MV_W(MV_W), .HYST_MV(HYST_MV)) u_decide (
    .clk(clk), .rst(rst), .main_mv(main_mv), .batt_mv(batt_mv),
    .trip_mv(trip_mv), .want_batt(want_batt)
  );

  swo_bbm u_bbm (
    .clk(clk), .rst(rst), .want_batt(want_batt),
    .main_en(main_en), .batt_en(batt_en), .batt_on(batt_on)
  );

  assign backup_mode = want_batt;
endmodule

// File: rtl/batt_switchover_chk.sv
module batt_switchover_chk #(
  parameter int MV_W = 13
) (
  input logic            clk,
  input logic            rst,
  input logic [MV_W-1:0] main_mv,
  input logic [MV_W-1:0] trip_mv,
  input logic            main_en,
  input logic            batt_en,
  input logic            batt_on,
  input logic            backup_mode
);
  // R7
  never_both_chk: assert property (@(posedge clk) disable iff (rst)
    !(main_en && batt_en));
  // R8
  batt_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(batt_en) |-> !$past(main_en));
  // R8
  main_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(main_en) |-> !$past(batt_en));
  // R2
  above_trip_chk: assert property (@(posedge clk) disable iff (rst)
    $past(main_mv > trip_mv) |-> !backup_mode);
  // R10
  batt_after_backup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(batt_on) |-> $past(backup_mode));
endmodule

bind batt_switchover batt_switchover_chk #(.MV_W(MV_W)) u_chk (
  .clk(clk), .rst(rst), .main_mv(main_mv), .trip_mv(trip_mv),
  .main_en(main_en), .batt_en(batt_en), .batt_on(batt_on),
  .backup_mode(backup_mode)
);

// File: tb/batt_switchover_bench.sv
module batt_switchover_bench;
  localparam int MV_W = 13;
  localparam int HYS  = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [MV_W-1:0] main_mv = '0, batt_mv = '0, trip_mv = '0;
  logic main_en, batt_en, batt_on, backup_mode;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  bit model_batt = 1'b0;

  always #5 clk = ~clk;

  batt_switchover #(.MV_W(MV_W), .HYST_MV(HYS)) u_batt_switchover (
    .clk(clk), .rst(rst), .main_mv(main_mv), .batt_mv(batt_mv),
    .trip_mv(trip_mv), .main_en(main_en), .batt_en(batt_en),
    .batt_on(batt_on), .backup_mode(backup_mode)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick_sample();
    @(posedge clk);
    #1;
  endtask

  task automatic apply(input int m, input int b, input int t);
    @(negedge clk);
    main_mv = m[MV_W-1:0];
    batt_mv = b[MV_W-1:0];
    trip_mv = t[MV_W-1:0];
  endtask

  // Model step; returns the rule tag that decided.
  function automatic string model_step(input int m, input int b, input int t);
    if (m > t) begin model_batt = 1'b0; return "R2"; end
    if (m < b - HYS) begin model_batt = 1'b1; return "R3"; end
    if (m > b + HYS) begin model_batt = 1'b0; return "R4"; end
    return (b < HYS) ? "R6" : "R5";
  endfunction

  task automatic settle_check(input int m, input int b, input int t);
    string tag;
    apply(m, b, t);
    tag = model_step(m, b, t);
    repeat (3) tick_sample();
    chk(backup_mode == model_batt, {tag, " backup_mode"}, backup_mode, model_batt);
    chk(batt_en == model_batt && main_en == !model_batt, {tag, " enables"},
        {main_en, batt_en}, {!model_batt, model_batt});
    chk(!(main_en && batt_en), "R7 both enables", {main_en, batt_en}, 0);
    chk(batt_on == batt_en, "R9 batt_on", batt_on, batt_en);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int batts[7] = '{0, 10, 29, 30, 31, 1500, 3000};
    int trips[3] = '{0, 2600, 4000};

    apply(3300, 3000, 2600);
    repeat (2) tick_sample();
    chk(main_en && !batt_en && !batt_on && !backup_mode, "R1 during reset",
        {main_en, batt_en, batt_on, backup_mode}, 4'b1000);
    @(negedge clk); rst = 1'b0;
    tick_sample();
    chk(main_en && !batt_en && !batt_on && !backup_mode, "R1 after reset",
        {main_en, batt_en, batt_on, backup_mode}, 4'b1000);

    // R8 / R10 cycle timing: main drops below battery band under trip
    apply(2000, 3000, 2600);
    tick_sample();
    chk(backup_mode == 1'b1, "R10 decision edge", backup_mode, 1);
    chk(main_en == 1'b1 && batt_en == 1'b0, "R8 before gap", {main_en, batt_en}, 2'b10);
    tick_sample();
    chk(!main_en && !batt_en && !batt_on, "R8 gap cycle", {main_en, batt_en}, 0);
    tick_sample();
    chk(batt_en && batt_on && !main_en, "R8 battery closes", {main_en, batt_en}, 2'b01);
    // and back, through R2
    apply(3300, 3000, 2600);
    tick_sample();
    chk(backup_mode == 1'b0, "R10 decision back", backup_mode, 0);
    chk(batt_en == 1'b1, "R8 battery held one more edge", batt_en, 1);
    tick_sample();
    chk(!main_en && !batt_en && !batt_on, "R8 gap on return", {main_en, batt_en}, 0);
    tick_sample();
    chk(main_en && !batt_en, "R8 main closes", {main_en, batt_en}, 2'b10);
    model_batt = 1'b0;

    // Exact band edges, trip high so tier two decides
    settle_check(2970, 3000, 4000);  // R5 hold main at lower edge
    settle_check(2969, 3000, 4000);  // R3 just below
    settle_check(3030, 3000, 4000);  // R5 hold battery at upper edge
    settle_check(3031, 3000, 4000);  // R4 just above
    settle_check(0, 10, 4000);       // R6 no wrap
    settle_check(5000, 6000, 4999);  // R2 above trip, battery higher

    // Ramps down then up across battery and trip levels
    foreach (batts[i]) foreach (trips[j]) begin
      for (int m = 5000; m >= 0; m -= 23) settle_check(m, batts[i], trips[j]);
      for (int m = 0; m <= 5000; m += 23) settle_check(m, batts[i], trips[j]);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule